// File: doc/BRIEF.md
# Two-Channel Peripheral DMA Controller

This block moves data between peripheral registers and RAM without the processor. Each of its two channels is tied to one peripheral register whose address does not change. A second pointer walks through RAM in steps of one or two bytes. Software programs four registers per channel: the peripheral address, the RAM address, a unit count and a control word. Software then arms the channel.

After arming, each unit transfer starts on a pulse from the one request line that the channel selects, or on a software trigger. Each unit is an atomic read followed by a write on a single-master bus. The bus has a valid/ready handshake and byte or halfword width.

When the programmed count runs out, the channel disarms itself and pulses its interrupt. Software may instead disarm a channel early. In that case the channel freezes where it stands and raises no interrupt. If both channels want the bus at once, channel 0 wins.

Top module: `tcdma_top`

## Requirements
- R1: After reset every channel register reads zero, the bus is idle (`bus_valid` low) and `irq` is zero.
- R2: The mode is `ctrl[1:0]`. Bit 1 clear moves peripheral to RAM; bit 1 set moves RAM to peripheral. Bit 0 set uses halfword accesses (`bus_size`=1); bit 0 clear uses byte accesses. A byte write carries zeros in `bus_wdata[15:8]` and changes only the addressed byte.
- R3: The peripheral address stays the same for every unit. The RAM address register advances by 1 in byte modes and by 2 in halfword modes after each completed unit.
- R4: The count register (`reg_addr`=2, 10 bits) drops by one per completed unit. A programmed zero runs 1024 units.
- R5: When the last unit completes, run bit `ctrl[6]` clears by itself and `irq[ch]` is high for exactly one cycle.
- R6: Writing `ctrl` with bit 6 clear stops the channel. Its count and RAM address keep their values, no interrupt follows, and later requests are ignored.
- R7: A unit starts only on a pulse of `req_lines[ctrl[5:2]]` while the channel runs. Pulses on other lines have no effect.
- R8: A `ctrl` write with bit 6 and bit 7 both set arms the channel and starts one unit. Bit 7 with bit 6 clear starts nothing. Bit 7 reads back as zero.
- R9: A request that arrives while the channel is busy or already pending is kept as one pending request, so it adds at most one unit.
- R10: When both channels have pending requests while the bus is free, channel 0 is served first.
- R11: In halfword modes the RAM-side bus address has bit 0 forced to zero.
- R12: Each unit is a read followed immediately by a write. Address and direction are held while `bus_ready` is low.
- Register map: `reg_addr` 0 = peripheral address, 1 = RAM address, 2 = count, 3 = control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_ch | input | 1 | Channel selected for register access |
| reg_addr | input | 2 | Register index within the channel |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data (combinational) |
| req_lines | input | 16 | Peripheral request pulses |
| bus_valid | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_size | output | 1 | 1 = halfword, 0 = byte |
| bus_addr | output | 20 | Bus byte address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Access completes this cycle |
| irq | output | 2 | Per-channel completion pulse |

## Verification
The checker watches properties that must hold on every cycle:
- even RAM-side halfword addresses;
- zero upper byte on byte writes;
- a stable request and a read-then-write order under stalls;
- single-cycle, one-hot interrupts that come only from a completed unit;
- grants that respect channel 0's priority;
- no interrupt after an early stop.

Some behaviours only the directed scenarios can show:
- data landing at the right addresses;
- the count and RAM address values after partial runs;
- 1024 units for a zero count;
- requests folding into one pending request;
- ignored request lines.

// File: rtl/tcdma_pkg.sv
package tcdma_pkg;
  typedef enum logic [1:0] {
    REG_PADDR = 2'd0,
    REG_RADDR = 2'd1,
    REG_COUNT = 2'd2,
    REG_CTRL  = 2'd3
  } reg_sel_e;

  localparam int CTRL_SRC_LSB  = 2;
  localparam int CTRL_RUN_BIT  = 6;
  localparam int CTRL_TRIG_BIT = 7;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2
  } mover_state_e;
endpackage

// File: rtl/tcdma_channel.sv
module tcdma_channel
  import tcdma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 10,
  parameter int SRC_W  = 4,
  localparam int REQ_N = 2 ** SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_reg,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [1:0]        rd_reg,
  input  logic [REQ_N-1:0]  req_lines,
  input  logic              grant,
  input  logic              done,
  output logic [ADDR_W-1:0] periph_addr,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [1:0]        mode,
  output logic              run,
  output logic              pending,
  output logic              irq,
  output logic [ADDR_W-1:0] rd_data
);
  logic [CNT_W-1:0] count_q;
  logic [SRC_W-1:0] src_q;
  logic wr_p, wr_r, wr_c, wr_k;
  logic stop_sw, accept_done, last_unit, hw_req, sw_go, run_n;

  function automatic logic [ADDR_W-1:0] ram_step(input logic [ADDR_W-1:0] a,
                                                  input logic half);
    return a + (half ? ADDR_W'(2) : ADDR_W'(1));
  endfunction

  assign wr_p        = wr_en && (wr_reg == REG_PADDR);
  assign wr_r        = wr_en && (wr_reg == REG_RADDR);
  assign wr_c        = wr_en && (wr_reg == REG_COUNT);
  assign wr_k        = wr_en && (wr_reg == REG_CTRL);
  assign stop_sw     = wr_k && !wr_data[CTRL_RUN_BIT];
  assign accept_done = done && run && !stop_sw;
  assign last_unit   = accept_done && (count_q == CNT_W'(1));
  assign hw_req      = req_lines[src_q];
  assign sw_go       = wr_k && wr_data[CTRL_RUN_BIT] && wr_data[CTRL_TRIG_BIT];

  always_comb begin
    if (wr_k)           run_n = wr_data[CTRL_RUN_BIT];
    else if (last_unit) run_n = 1'b0;
    else                run_n = run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periph_addr <= '0;
      ram_addr    <= '0;
      count_q     <= '0;
      mode        <= '0;
      src_q       <= '0;
      run         <= 1'b0;
      pending     <= 1'b0;
      irq         <= 1'b0;
    end else begin
      run     <= run_n;
      pending <= run_n && ((pending && !grant) || (run && hw_req) || sw_go);
      irq     <= last_unit;
      if (wr_p) periph_addr <= wr_data;
      if (wr_r)             ram_addr <= wr_data;
      else if (accept_done) ram_addr <= ram_step(ram_addr, mode[0]);
      if (wr_c)             count_q <= wr_data[CNT_W-1:0];
      else if (accept_done) count_q <= count_q - CNT_W'(1);
      if (wr_k) begin
        mode  <= wr_data[1:0];
        src_q <= wr_data[CTRL_SRC_LSB +: SRC_W];
      end
    end
  end

  always_comb begin
    unique case (rd_reg)
      REG_PADDR: rd_data = periph_addr;
      REG_RADDR: rd_data = ram_addr;
      REG_COUNT: rd_data = ADDR_W'(count_q);
      default:   rd_data = ADDR_W'({run, src_q, mode});
    endcase
  end
endmodule

// File: rtl/tcdma_arbiter.sv
module tcdma_arbiter #(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              idle,
  input  logic [NUM_CH-1:0] pending,
  output logic [NUM_CH-1:0] grant,
  output logic [CH_W-1:0]   grant_id,
  output logic              grant_any
);
  always_comb begin
    grant    = '0;
    grant_id = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (idle && pending[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        grant_id = CH_W'(i);
      end
    end
  end

  assign grant_any = |grant;
endmodule

// File: rtl/tcdma_mover.sv
module tcdma_mover
  import tcdma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   start_ch,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              half,
  input  logic              ram_is_src,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              idle,
  output logic              bus_valid,
  output logic              bus_we,
  output logic              bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              done,
  output logic [CH_W-1:0]   done_ch,
  output logic              ram_access
);
  mover_state_e      state;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [DATA_W-1:0] data_q;
  logic              ram_src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= MV_IDLE;
      done_ch   <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      data_q    <= '0;
      bus_size  <= 1'b0;
      ram_src_q <= 1'b0;
    end else begin
      unique case (state)
        MV_IDLE: if (start) begin
          state     <= MV_READ;
          done_ch   <= start_ch;
          src_q     <= src_addr;
          dst_q     <= dst_addr;
          bus_size  <= half;
          ram_src_q <= ram_is_src;
        end
        MV_READ: if (bus_ready) begin
          data_q <= bus_rdata;
          state  <= MV_WRITE;
        end
        MV_WRITE: if (bus_ready) state <= MV_IDLE;
        default: state <= MV_IDLE;
      endcase
    end
  end

  assign idle       = (state == MV_IDLE);
  assign bus_valid  = !idle;
  assign bus_we     = (state == MV_WRITE);
  assign bus_addr   = bus_we ? dst_q : src_q;
  assign bus_wdata  = bus_size ? data_q : {{(DATA_W-8){1'b0}}, data_q[7:0]};
  assign done       = bus_we && bus_ready;
  assign ram_access = bus_valid && (bus_we ? !ram_src_q : ram_src_q);
endmodule

// File: rtl/tcdma_top.sv
module tcdma_top #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10,
  parameter int SRC_W  = 4,
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int REQ_N = 2 ** SRC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CH_W-1:0]   reg_ch,
  input  logic [1:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic [REQ_N-1:0]  req_lines,
  output logic              bus_valid,
  output logic              bus_we,
  output logic              bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic [NUM_CH-1:0] irq
);
  logic [ADDR_W-1:0] ch_paddr [NUM_CH];
  logic [ADDR_W-1:0] ch_raddr [NUM_CH];
  logic [ADDR_W-1:0] ch_rd    [NUM_CH];
  logic [1:0]        ch_mode  [NUM_CH];
  logic [NUM_CH-1:0] ch_run, ch_pend, ch_grant, ch_done;

  logic              mover_idle, grant_any, unit_done, ram_access;
  logic [CH_W-1:0]   grant_id, unit_ch;
  logic              sel_half, sel_to_periph;
  logic [ADDR_W-1:0] sel_ram, start_src, start_dst;

  function automatic logic [ADDR_W-1:0] ram_bus_addr(input logic [ADDR_W-1:0] a,
                                                      input logic half);
    return half ? {a[ADDR_W-1:1], 1'b0} : a;
  endfunction

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_done[i] = unit_done && (unit_ch == CH_W'(i));
    tcdma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SRC_W(SRC_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr && (reg_ch == CH_W'(i))),
      .wr_reg     (reg_addr),
      .wr_data    (reg_wdata),
      .rd_reg     (reg_addr),
      .req_lines  (req_lines),
      .grant      (ch_grant[i]),
      .done       (ch_done[i]),
      .periph_addr(ch_paddr[i]),
      .ram_addr   (ch_raddr[i]),
      .mode       (ch_mode[i]),
      .run        (ch_run[i]),
      .pending    (ch_pend[i]),
      .irq        (irq[i]),
      .rd_data    (ch_rd[i])
    );
  end

  assign reg_rdata = ch_rd[reg_ch];

  tcdma_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .idle     (mover_idle),
    .pending  (ch_pend),
    .grant    (ch_grant),
    .grant_id (grant_id),
    .grant_any(grant_any)
  );

  always_comb begin
    sel_half      = ch_mode[grant_id][0];
    sel_to_periph = ch_mode[grant_id][1];
    sel_ram       = ram_bus_addr(ch_raddr[grant_id], sel_half);
    start_src     = sel_to_periph ? sel_ram : ch_paddr[grant_id];
    start_dst     = sel_to_periph ? ch_paddr[grant_id] : sel_ram;
  end

  tcdma_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (grant_any),
    .start_ch  (grant_id),
    .src_addr  (start_src),
    .dst_addr  (start_dst),
    .half      (sel_half),
    .ram_is_src(sel_to_periph),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .idle      (mover_idle),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .done      (unit_done),
    .done_ch   (unit_ch),
    .ram_access(ram_access)
  );
endmodule

// File: rtl/tcdma_checker.sv
module tcdma_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic              bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ready,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] grant,
  input logic [NUM_CH-1:0] pending,
  input logic [NUM_CH-1:0] run,
  input logic              unit_done,
  input logic [CH_W-1:0]   unit_ch,
  input logic              ram_access
);
  assert_halfword_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_size && ram_access |-> !bus_addr[0]);

  assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_we && !bus_size |-> bus_wdata[DATA_W-1:8] == '0);

  assert_hold_until_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we));

  assert_read_then_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_we && bus_ready |=> bus_valid && bus_we);

  assert_irq_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_irq_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |=> !irq[i]);

    assert_irq_from_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> $past(unit_done && (unit_ch == CH_W'(i))));

    assert_abort_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run[i]) && !irq[i] |=> !irq[i]);

    if (i > 0) begin : g_prio
      assert_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant[i] |-> !pending[0]);
    end
  end
endmodule

bind tcdma_top tcdma_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_size  (bus_size),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ready (bus_ready),
  .irq       (irq),
  .grant     (ch_grant),
  .pending   (ch_pend),
  .run       (ch_run),
  .unit_done (unit_done),
  .unit_ch   (unit_ch),
  .ram_access(ram_access)
);

// File: tb/tcdma_top_bench.sv
module tcdma_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [0:0]  reg_ch = '0;
  logic [1:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic [15:0] req_lines = '0;
  logic        bus_valid, bus_we, bus_size;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_ready = 1'b1;
  logic [1:0]  irq;

  logic        stall_on = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  mem [0:4095];
  logic [19:0] wlog [0:15];
  int wr_cnt = 0, rd_cnt = 0, irq0_cnt = 0, irq1_cnt = 0;
  logic irq_prev = 1'b0, irq_long = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tcdma_top u_tcdma_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ch(reg_ch), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_lines(req_lines),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .irq(irq)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 11);
  endfunction

  assign bus_rdata = bus_size ? {mem[{bus_addr[11:1], 1'b1}], mem[{bus_addr[11:1], 1'b0}]}
                              : {8'hA5, mem[bus_addr[11:0]]};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
      wr_cnt <= 0; rd_cnt <= 0; irq0_cnt <= 0; irq1_cnt <= 0;
      irq_prev <= 1'b0; irq_long <= 1'b0;
    end else begin
      if (bus_valid && bus_ready && bus_we) begin
        if (bus_size) begin
          mem[{bus_addr[11:1], 1'b1}] <= bus_wdata[15:8];
          mem[{bus_addr[11:1], 1'b0}] <= bus_wdata[7:0];
        end else begin
          mem[bus_addr[11:0]] <= bus_wdata[7:0];
        end
        wlog[wr_cnt[3:0]] <= bus_addr;
        wr_cnt <= wr_cnt + 1;
      end
      if (bus_valid && bus_ready && !bus_we) rd_cnt <= rd_cnt + 1;
      if (irq[0]) irq0_cnt <= irq0_cnt + 1;
      if (irq[1]) irq1_cnt <= irq1_cnt + 1;
      if ((irq != 2'b00) && irq_prev) irq_long <= 1'b1;
      irq_prev <= |irq;
    end
  end

  always @(negedge clk) begin
    tick      <= ~tick;
    bus_ready <= !stall_on || tick;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int ch, input logic [1:0] a, input logic [19:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_ch = ch[0]; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input int ch, input logic [1:0] a, output logic [19:0] d);
    @(negedge clk);
    reg_ch = ch[0]; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [19:0] ctrl(input int mode, input int src, input bit run, input bit trig);
    return 20'({trig, run, 4'(src), 2'(mode)});
  endfunction

  task automatic pulse(input int line);
    @(negedge clk); req_lines[line] = 1'b1;
    @(negedge clk); req_lines = '0;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int ch, input int pa, input int ra, input int cnt);
    wr_reg(ch, 2'd0, 20'(pa));
    wr_reg(ch, 2'd1, 20'(ra));
    wr_reg(ch, 2'd2, 20'(cnt));
  endtask

  task automatic t_reset;
    logic [19:0] v;
    for (int ch = 0; ch < 2; ch++)
      for (int a = 0; a < 4; a++) begin
        rd_reg(ch, 2'(a), v);
        chk("R1 register zero after reset", v, 0);
      end
    chk("R1 bus idle", bus_valid, 0);
    chk("R1 irq low", irq, 0);
  endtask

  task automatic t_byte_in;
    logic [19:0] v;
    int r0;
    setup(0, 'hF40, 'h200, 3);
    wr_reg(0, 2'd3, ctrl(0, 3, 1, 0));
    r0 = rd_cnt;
    pulse(5); idle_wait(10);
    chk("R7 wrong request line ignored (reads)", rd_cnt, r0);
    rd_reg(0, 2'd2, v); chk("R7 count unchanged", v, 3);
    for (int k = 0; k < 3; k++) begin pulse(3); idle_wait(10); end
    for (int k = 0; k < 3; k++)
      chk("R3 fixed peripheral source byte copied", mem['h200 + k], pat('hF40));
    chk("R2 byte mode leaves next byte", mem['h203], pat('h203));
    rd_reg(0, 2'd1, v); chk("R3 RAM address +1 per unit", v, 'h203);
    rd_reg(0, 2'd2, v); chk("R4 count reaches zero", v, 0);
    rd_reg(0, 2'd3, v); chk("R5 run cleared on completion", v[6], 0);
    chk("R5 one completion irq", irq0_cnt, 1);
  endtask

  task automatic t_half_out_sw;
    logic [19:0] v;
    int r0;
    setup(1, 'hF44, 'h300, 2);
    r0 = rd_cnt;
    wr_reg(1, 2'd3, ctrl(3, 2, 0, 1)); idle_wait(10);
    chk("R8 trigger without run starts nothing", rd_cnt, r0);
    wr_reg(1, 2'd3, ctrl(3, 2, 1, 1)); idle_wait(10);
    chk("R8 sw trigger low byte", mem['hF44], pat('h300));
    chk("R2 halfword high byte", mem['hF45], pat('h301));
    rd_reg(1, 2'd2, v); chk("R8 one unit from trigger", v, 1);
    rd_reg(1, 2'd3, v); chk("R8 trigger bit reads zero, run set", v[7:6], 2'b01);
    pulse(2); idle_wait(10);
    chk("R3 RAM source +2 (low)", mem['hF44], pat('h302));
    chk("R3 RAM source +2 (high)", mem['hF45], pat('h303));
    rd_reg(1, 2'd1, v); chk("R3 RAM address +2 per unit", v, 'h304);
    chk("R5 channel 1 irq", irq1_cnt, 1);
  endtask

  task automatic t_odd_half;
    logic [19:0] v;
    setup(0, 'hF48, 'h401, 2);
    wr_reg(0, 2'd3, ctrl(1, 4, 1, 1)); idle_wait(10);
    chk("R11 odd address forced even (low)", mem['h400], pat('hF48));
    chk("R11 odd address forced even (high)", mem['h401], pat('hF49));
    rd_reg(0, 2'd1, v); chk("R11 stored address steps by 2", v, 'h403);
    pulse(4); idle_wait(10);
    chk("R11 second unit at 0x402", mem['h402], pat('hF48));
    chk("R11 byte past block untouched", mem['h404], pat('h404));
  endtask

  task automatic t_byte_out_stall;
    int w0;
    stall_on = 1'b1;
    setup(1, 'hF50, 'h500, 1);
    wr_reg(1, 2'd3, ctrl(2, 6, 1, 0));
    w0 = wr_cnt;
    pulse(6); idle_wait(20);
    chk("R12 one write under stalls", wr_cnt - w0, 1);
    chk("R2 RAM to peripheral byte", mem['hF50], pat('h500));
    chk("R2 byte write leaves neighbour", mem['hF51], pat('hF51));
    chk("R5 irq after single unit", irq1_cnt, 2);
    stall_on = 1'b0;
  endtask

  task automatic t_busy_latch;
    logic [19:0] v;
    int w0;
    stall_on = 1'b1;
    setup(0, 'hF40, 'h600, 4);
    wr_reg(0, 2'd3, ctrl(0, 7, 1, 0));
    w0 = wr_cnt;
    pulse(7); pulse(7); pulse(7);
    idle_wait(30);
    chk("R9 requests while busy fold into one", wr_cnt - w0, 2);
    rd_reg(0, 2'd2, v); chk("R9 count after two units", v, 2);
    rd_reg(0, 2'd3, v); chk("R9 channel still running", v[6], 1);
    wr_reg(0, 2'd3, ctrl(0, 7, 0, 0));
    stall_on = 1'b0;
  endtask

  task automatic t_priority;
    int w0;
    setup(0, 'hF40, 'h700, 1);
    setup(1, 'hF42, 'h780, 1);
    wr_reg(0, 2'd3, ctrl(0, 8, 1, 0));
    wr_reg(1, 2'd3, ctrl(0, 9, 1, 0));
    w0 = wr_cnt;
    @(negedge clk); req_lines[8] = 1'b1; req_lines[9] = 1'b1;
    @(negedge clk); req_lines = '0;
    idle_wait(20);
    chk("R10 two units done", wr_cnt - w0, 2);
    chk("R10 channel 0 served first", wlog[w0 & 15], 'h700);
    chk("R10 channel 1 served second", wlog[(w0 + 1) & 15], 'h780);
  endtask

  task automatic t_abort;
    logic [19:0] v;
    int w0, i0;
    setup(1, 'hF40, 'h800, 5);
    wr_reg(1, 2'd3, ctrl(0, 10, 1, 0));
    pulse(10); idle_wait(10);
    pulse(10); idle_wait(10);
    i0 = irq1_cnt;
    wr_reg(1, 2'd3, ctrl(0, 10, 0, 0));
    rd_reg(1, 2'd2, v); chk("R6 count frozen", v, 3);
    rd_reg(1, 2'd1, v); chk("R6 RAM address frozen", v, 'h802);
    w0 = wr_cnt;
    pulse(10); idle_wait(10);
    chk("R6 no transfer after stop", wr_cnt, w0);
    chk("R6 no irq on stop", irq1_cnt, i0);
    rd_reg(1, 2'd2, v); chk("R6 count still frozen", v, 3);
  endtask

  task automatic t_count_zero;
    logic [19:0] v;
    int i0;
    i0 = irq0_cnt;
    setup(0, 'hF40, 'h000, 0);
    wr_reg(0, 2'd3, ctrl(0, 11, 1, 0));
    for (int k = 0; k < 1023; k++) begin pulse(11); idle_wait(5); end
    chk("R4 no irq before unit 1024", irq0_cnt, i0);
    rd_reg(0, 2'd2, v); chk("R4 one unit left", v, 1);
    pulse(11); idle_wait(8);
    chk("R4 irq after unit 1024", irq0_cnt, i0 + 1);
    rd_reg(0, 2'd1, v); chk("R4 RAM address after 1024 units", v, 'h400);
    rd_reg(0, 2'd3, v); chk("R5 run cleared", v[6], 0);
    chk("R5 irq pulses one cycle wide", irq_long, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_byte_in;
    t_half_out_sw;
    t_odd_half;
    t_byte_out_stall;
    t_busy_latch;
    t_priority;
    t_abort;
    t_count_zero;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule